// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block is one cell of a programmable logic fabric. Seven AND terms are each formed over a shared input vector. Three of them are ORed. The OR result can be inverted or XORed by a fourth term. The result then feeds a storage element whose behaviour is picked by configuration: D, T, JK or SR flip-flop, a transparent latch, or a straight combinational bypass. The remaining three terms give a forced set, a forced clear and a clock that is built from the array. The macrocell output is also returned as a feedback signal for the surrounding array.

The configuration is a static input and is never programmed by the block. It has two parts. The literal fields of every term are live wires. The mode, the clock source and the XOR enable are captured only while reset is held. The block moves no data stream, so every pin is a plain level signal. There is no valid/ready handshake and no back-pressure: a new input vector is evaluated every cycle.

Top module: `pld_macrocell`

## Requirements
- R1: Every term has two configuration bits per input, at bit 2*(t*N_IN+i) of `cfg_lits` for term t and input i. The codes are 00 ignore the input, 01 use it as is, 10 use its complement, and 11 force the term to 0. A term whose fields are all 00 evaluates to 1.
- R2: Term roles by index: 0, 1 and 2 are ORed into the sum, 3 is the auxiliary term, 4 is preset, 5 is clear and 6 is the array clock.
- R3: The data value is the sum XOR (XOR enable AND auxiliary term). In mode 0 (D) with the system clock selected, `mc_out` takes the data value at each rising edge of `clk` and not before.
- R4: In mode 5 (bypass), and in the unused codes 6 and 7, `mc_out` equals the data value in the same cycle, with no clock edge.
- R5: In mode 1 (T), the state inverts at an update edge when the data value is 1 and holds when it is 0.
- R6: In mode 2 (JK), J is the sum and K is the auxiliary term. 10 sets, 01 clears, 00 holds and 11 toggles.
- R7: In mode 3 (SR), S is the sum and R is the auxiliary term. 10 sets, 01 clears, and both 00 and 11 hold the current value.
- R8: In mode 4 (latch), the gate is term 6. While the gate is high, `mc_out` follows the data value in the same cycle, and the state captures it at each `clk` edge. While the gate is low, the value captured at the last edge with the gate high is held.
- R9: With clock select 1, the flip-flop modes update only at a `clk` edge where term 6 is high and was low at the previous edge.
- R10: Preset forces `mc_out` to 1 and clear forces it to 0 in the same cycle, without an edge. Clear wins when both are active. The state keeps the forced value after release until the next update.
- R11: Mode, clock select and XOR enable are captured only while `rst_n` is low, and later changes on those pins have no effect. Reset sets the state to 0.
- R12: `mc_fb` always carries the same value as `mc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; configuration capture window |
| in_vec | input | N_IN | Input vector shared by all terms |
| cfg_lits | input | 14*N_IN | Two-bit literal field per term and input |
| cfg_mode | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4 latch, 5 bypass |
| cfg_clk_array | input | 1 | 0 system clock every edge, 1 rising edges of term 6 |
| cfg_xor_en | input | 1 | Enables the auxiliary term into the XOR |
| mc_out | output | 1 | Macrocell output |
| mc_fb | output | 1 | Feedback copy of the output for the array |

## Verification
The bench builds the block with N_IN set to 6. That width gives each role its own input lane: data, auxiliary, preset, clear and clock term. Because of this, every mode and both clock sources can be driven one signal at a time without rewriting literals between steps. The all-ignore and force-zero literal codes are both reached by reshaping one sum term. The preset/clear overlap and the unused mode code 7 are also within reach.

// File: rtl/pld_mc_pkg.sv
`timescale 1ns/1ps
package pld_mc_pkg;

  localparam int PT_COUNT   = 7;
  localparam int PT_SUM0    = 0;
  localparam int PT_SUM1    = 1;
  localparam int PT_SUM2    = 2;
  localparam int PT_AUX     = 3;
  localparam int PT_PRESET  = 4;
  localparam int PT_CLEAR   = 5;
  localparam int PT_CLOCK   = 6;

  typedef enum logic [2:0] {
    MODE_D      = 3'd0,
    MODE_T      = 3'd1,
    MODE_JK     = 3'd2,
    MODE_SR     = 3'd3,
    MODE_LATCH  = 3'd4,
    MODE_BYPASS = 3'd5
  } mc_mode_e;

  typedef enum logic [1:0] {
    LIT_ANY   = 2'b00,
    LIT_TRUE  = 2'b01,
    LIT_COMP  = 2'b10,
    LIT_NEVER = 2'b11
  } lit_e;

  typedef struct packed {
    mc_mode_e mode;
    logic     clk_from_array;
    logic     xor_en;
  } mc_cfg_t;

  function automatic mc_mode_e norm_mode(logic [2:0] raw);
    if (raw > 3'd5) return MODE_BYPASS;
    return mc_mode_e'(raw);
  endfunction

endpackage

// File: rtl/mc_pterm.sv
`timescale 1ns/1ps
module mc_pterm
  import pld_mc_pkg::*;
#(
  parameter int N_IN = 8
) (
  input  logic [N_IN-1:0]   in_vec,
  input  logic [2*N_IN-1:0] lits,
  output logic              term
);

  logic [N_IN-1:0] hit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    logic [1:0] fld;
    assign fld    = lits[2*i +: 2];
    assign hit[i] = (fld == LIT_ANY)
                  | ((fld == LIT_TRUE) &  in_vec[i])
                  | ((fld == LIT_COMP) & ~in_vec[i]);
  end

  assign term = &hit;

endmodule

// File: rtl/mc_front.sv
`timescale 1ns/1ps
module mc_front
  import pld_mc_pkg::*;
#(
  parameter int N_IN = 8
) (
  input  logic [N_IN-1:0]            in_vec,
  input  logic [PT_COUNT*2*N_IN-1:0] cfg_lits,
  input  logic                       xor_en,
  output logic                       d_val,
  output logic                       j_val,
  output logic                       k_val,
  output logic                       pre_t,
  output logic                       clr_t,
  output logic                       clk_t
);

  localparam int FLD_W = 2 * N_IN;

  logic [PT_COUNT-1:0] pt;
  logic                sum;

  for (genvar t = 0; t < PT_COUNT; t++) begin : g_term
    mc_pterm #(.N_IN(N_IN)) u_term (
      .in_vec (in_vec),
      .lits   (cfg_lits[t*FLD_W +: FLD_W]),
      .term   (pt[t])
    );
  end

  assign sum   = pt[PT_SUM0] | pt[PT_SUM1] | pt[PT_SUM2];
  assign d_val = sum ^ (xor_en & pt[PT_AUX]);
  assign j_val = sum;
  assign k_val = pt[PT_AUX];
  assign pre_t = pt[PT_PRESET];
  assign clr_t = pt[PT_CLEAR];
  assign clk_t = pt[PT_CLOCK];

endmodule

// File: rtl/mc_cfg_hold.sv
`timescale 1ns/1ps
module mc_cfg_hold
  import pld_mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_in,
  input  logic       clk_array_in,
  input  logic       xor_en_in,
  output mc_cfg_t    cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.mode           <= norm_mode(mode_in);
      cfg_q.clk_from_array <= clk_array_in;
      cfg_q.xor_en         <= xor_en_in;
    end
  end

endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store
  import pld_mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  mc_cfg_t cfg,
  input  logic    d_val,
  input  logic    j_val,
  input  logic    k_val,
  input  logic    pre_t,
  input  logic    clr_t,
  input  logic    clk_t,
  output logic    q_out
);

  logic q;
  logic ck_prev;
  logic upd_en;
  logic q_nxt;

  assign upd_en = cfg.clk_from_array ? (clk_t & ~ck_prev) : 1'b1;

  always_comb begin
    unique case (cfg.mode)
      MODE_D:  q_nxt = d_val;
      MODE_T:  q_nxt = q ^ d_val;
      MODE_JK: q_nxt = (j_val & ~q) | (~k_val & q);
      MODE_SR: begin
        if (j_val & ~k_val)      q_nxt = 1'b1;
        else if (k_val & ~j_val) q_nxt = 1'b0;
        else                     q_nxt = q;
      end
      default: q_nxt = d_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= 1'b0;
      ck_prev <= 1'b0;
    end else begin
      ck_prev <= clk_t;
      if (clr_t)                        q <= 1'b0;
      else if (pre_t)                   q <= 1'b1;
      else if (cfg.mode == MODE_LATCH)  q <= clk_t ? d_val : q;
      else if (cfg.mode == MODE_BYPASS) q <= d_val;
      else if (upd_en)                  q <= q_nxt;
    end
  end

  always_comb begin
    if (clr_t)                        q_out = 1'b0;
    else if (pre_t)                   q_out = 1'b1;
    else if (cfg.mode == MODE_BYPASS) q_out = d_val;
    else if (cfg.mode == MODE_LATCH)  q_out = clk_t ? d_val : q;
    else                              q_out = q;
  end

endmodule

// File: rtl/pld_macrocell.sv
`timescale 1ns/1ps
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int N_IN = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_IN-1:0]            in_vec,
  input  logic [PT_COUNT*2*N_IN-1:0] cfg_lits,
  input  logic [2:0]                 cfg_mode,
  input  logic                       cfg_clk_array,
  input  logic                       cfg_xor_en,
  output logic                       mc_out,
  output logic                       mc_fb
);

  mc_cfg_t cfg_q;
  logic    d_val, j_val, k_val, pre_t, clr_t, clk_t;
  logic    q_out;

  mc_cfg_hold u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_in      (cfg_mode),
    .clk_array_in (cfg_clk_array),
    .xor_en_in    (cfg_xor_en),
    .cfg_q        (cfg_q)
  );

  mc_front #(.N_IN(N_IN)) u_front (
    .in_vec   (in_vec),
    .cfg_lits (cfg_lits),
    .xor_en   (cfg_q.xor_en),
    .d_val    (d_val),
    .j_val    (j_val),
    .k_val    (k_val),
    .pre_t    (pre_t),
    .clr_t    (clr_t),
    .clk_t    (clk_t)
  );

  mc_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg   (cfg_q),
    .d_val (d_val),
    .j_val (j_val),
    .k_val (k_val),
    .pre_t (pre_t),
    .clr_t (clr_t),
    .clk_t (clk_t),
    .q_out (q_out)
  );

  assign mc_out = q_out;
  assign mc_fb  = q_out;

endmodule

// File: rtl/mc_checker.sv
`timescale 1ns/1ps
module mc_checker
  import pld_mc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       clk_array,
  input logic       d_val,
  input logic       j_val,
  input logic       k_val,
  input logic       pre_t,
  input logic       clr_t,
  input logic       clk_t,
  input logic       mc_out
);

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_t |-> !mc_out);

  p_preset_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_t && !clr_t) |-> mc_out);

  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BYPASS && !pre_t && !clr_t) |-> (mc_out == d_val));

  p_dflop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_D && !clk_array && !pre_t && !clr_t)
    |=> (pre_t || clr_t || mc_out == $past(d_val)));

  p_sr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SR && !clk_array && j_val && k_val && !pre_t && !clr_t)
    |=> (pre_t || clr_t || mc_out == $past(mc_out)));

  p_array_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_D && clk_array && !clk_t && !pre_t && !clr_t)
    |=> (pre_t || clr_t || mc_out == $past(mc_out)));

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(mode) && $stable(clk_array)));

endmodule

bind pld_macrocell mc_checker u_mc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (cfg_q.mode),
  .clk_array (cfg_q.clk_from_array),
  .d_val     (d_val),
  .j_val     (j_val),
  .k_val     (k_val),
  .pre_t     (pre_t),
  .clr_t     (clr_t),
  .clk_t     (clk_t),
  .mc_out    (mc_out)
);

// File: tb/test_pld_macrocell.sv
`timescale 1ns/1ps
module test_pld_macrocell;
  import pld_mc_pkg::*;

  localparam int N = 6;
  localparam int W = PT_COUNT * 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] in_vec = '0;
  logic [W-1:0] cfg_lits = '0;
  logic [2:0]   cfg_mode = 3'd0;
  logic         cfg_clk_array = 1'b0;
  logic         cfg_xor_en = 1'b0;
  logic         mc_out, mc_fb;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [1:0] lit [PT_COUNT][N];

  always #10 clk = ~clk;

  pld_macrocell #(.N_IN(N)) i_pld_macrocell (
    .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .cfg_lits(cfg_lits),
    .cfg_mode(cfg_mode), .cfg_clk_array(cfg_clk_array),
    .cfg_xor_en(cfg_xor_en), .mc_out(mc_out), .mc_fb(mc_fb)
  );

  task automatic load_lits();
    for (int t = 0; t < PT_COUNT; t++)
      for (int i = 0; i < N; i++)
        cfg_lits[(t*N+i)*2 +: 2] = lit[t][i];
  endtask

  task automatic term_one(int t, int idx, logic [1:0] f);
    for (int i = 0; i < N; i++) lit[t][i] = 2'b00;
    lit[t][idx] = f;
  endtask

  // in0 data, in1 aux, in3 preset, in4 clear, in5 clock; sums 1,2 forced 0 (R2)
  task automatic std_terms();
    term_one(0, 0, 2'b01);
    term_one(1, 0, 2'b11);
    term_one(2, 0, 2'b11);
    term_one(3, 1, 2'b01);
    term_one(4, 3, 2'b01);
    term_one(5, 4, 2'b01);
    term_one(6, 5, 2'b01);
    load_lits();
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [2:0] m, logic ca, logic xe);
    rst_n = 1'b0;
    cfg_mode = m; cfg_clk_array = ca; cfg_xor_en = xe;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    std_terms();
    in_vec = 6'b000001;
    do_reset(3'd0, 1'b0, 1'b0);
    chk("R11 state zero after reset", mc_out, 1'b0);
    chk("R12 feedback after reset", mc_fb, 1'b0);
    in_vec = '0;
    tick();
  endtask

  task automatic t_literals();
    std_terms();
    term_one(0, 0, 2'b01);
    lit[0][1] = 2'b10;
    for (int t = 3; t < PT_COUNT; t++) term_one(t, 0, 2'b11);
    load_lits();
    do_reset(3'd5, 1'b0, 1'b0);
    in_vec = 6'b000001; #1;
    chk("R1 true and complement hit", mc_out, 1'b1);
    in_vec = 6'b000011; #1;
    chk("R1 complement literal blocks", mc_out, 1'b0);
    in_vec = 6'b000000; #1;
    chk("R1 true literal blocks", mc_out, 1'b0);
    term_one(1, 0, 2'b00); load_lits(); #1;
    chk("R1 all-ignore term is one", mc_out, 1'b1);
    chk("R12 feedback follows", mc_fb, 1'b1);
    term_one(1, 2, 2'b11); load_lits(); #1;
    chk("R1 code 11 forces zero", mc_out, 1'b0);
    std_terms();
    do_reset(3'd7, 1'b0, 1'b0);
    in_vec = 6'b000001; #1;
    chk("R4 code 7 acts as bypass", mc_out, 1'b1);
    in_vec = '0;
  endtask

  task automatic t_xor();
    std_terms();
    do_reset(3'd5, 1'b0, 1'b1);
    in_vec = 6'b000011; #1;
    chk("R3 xor 1^1", mc_out, 1'b0);
    in_vec = 6'b000010; #1;
    chk("R3 xor 0^1", mc_out, 1'b1);
    cfg_xor_en = 1'b0;
    in_vec = 6'b000011; #1;
    chk("R11 xor enable change ignored", mc_out, 1'b0);
    do_reset(3'd5, 1'b0, 1'b0);
    in_vec = 6'b000011; #1;
    chk("R3 xor disabled passes sum", mc_out, 1'b1);
    in_vec = '0;
  endtask

  task automatic t_dflop();
    std_terms();
    do_reset(3'd0, 1'b0, 1'b0);
    in_vec = 6'b000001; #1;
    chk("R3 D holds before edge", mc_out, 1'b0);
    tick();
    chk("R3 D loads at edge", mc_out, 1'b1);
    in_vec = 6'b000000;
    tick();
    chk("R3 D loads zero", mc_out, 1'b0);
    cfg_mode = 3'd5;
    in_vec = 6'b000001; #1;
    chk("R11 mode change ignored", mc_out, 1'b0);
    tick();
    chk("R11 still registered", mc_out, 1'b1);
    cfg_mode = 3'd0;
    in_vec = '0;
  endtask

  task automatic t_tflop();
    std_terms();
    do_reset(3'd1, 1'b0, 1'b0);
    in_vec = 6'b000001;
    tick(); chk("R5 T toggle 1", mc_out, 1'b1);
    tick(); chk("R5 T toggle 2", mc_out, 1'b0);
    tick(); chk("R5 T toggle 3", mc_out, 1'b1);
    in_vec = '0;
    tick(); chk("R5 T hold", mc_out, 1'b1);
  endtask

  task automatic t_jk();
    std_terms();
    do_reset(3'd2, 1'b0, 1'b0);
    in_vec = 6'b000001; tick(); chk("R6 JK set", mc_out, 1'b1);
    in_vec = 6'b000000; tick(); chk("R6 JK hold", mc_out, 1'b1);
    in_vec = 6'b000010; tick(); chk("R6 JK clear", mc_out, 1'b0);
    in_vec = 6'b000011; tick(); chk("R6 JK toggle up", mc_out, 1'b1);
    tick(); chk("R6 JK toggle down", mc_out, 1'b0);
    in_vec = '0;
  endtask

  task automatic t_sr();
    std_terms();
    do_reset(3'd3, 1'b0, 1'b0);
    in_vec = 6'b000001; tick(); chk("R7 SR set", mc_out, 1'b1);
    in_vec = 6'b000011; tick(); chk("R7 SR both hold one", mc_out, 1'b1);
    in_vec = 6'b000010; tick(); chk("R7 SR reset", mc_out, 1'b0);
    in_vec = 6'b000011; tick(); chk("R7 SR both hold zero", mc_out, 1'b0);
    in_vec = '0;
  endtask

  task automatic t_latch();
    std_terms();
    do_reset(3'd4, 1'b0, 1'b0);
    in_vec = 6'b100001; #1;
    chk("R8 transparent same cycle", mc_out, 1'b1);
    tick();
    in_vec = 6'b000001; #1;
    chk("R8 gate low holds", mc_out, 1'b1);
    in_vec = 6'b000000; #1;
    chk("R8 data change ignored", mc_out, 1'b1);
    tick();
    chk("R8 hold across edge", mc_out, 1'b1);
    in_vec = 6'b100000; #1;
    chk("R8 gate high follows", mc_out, 1'b0);
    in_vec = '0;
    tick();
  endtask

  task automatic t_arrclk();
    std_terms();
    do_reset(3'd0, 1'b1, 1'b0);
    in_vec = 6'b000001;
    tick(); tick();
    chk("R9 no clock term edge", mc_out, 1'b0);
    in_vec = 6'b100001;
    tick(); chk("R9 rising term loads", mc_out, 1'b1);
    in_vec = 6'b100000;
    tick(); chk("R9 term held high no load", mc_out, 1'b1);
    in_vec = 6'b000000;
    tick(); chk("R9 term falling no load", mc_out, 1'b1);
    in_vec = 6'b100000;
    tick(); chk("R9 second rise loads", mc_out, 1'b0);
    in_vec = '0;
  endtask

  task automatic t_prclr();
    std_terms();
    do_reset(3'd0, 1'b0, 1'b0);
    in_vec = 6'b001000; #1;
    chk("R10 preset same cycle", mc_out, 1'b1);
    tick();
    in_vec = 6'b000000; #1;
    chk("R10 preset kept after release", mc_out, 1'b1);
    tick();
    chk("R10 next update resumes", mc_out, 1'b0);
    in_vec = 6'b011000; #1;
    chk("R10 clear wins over preset", mc_out, 1'b0);
    in_vec = 6'b001000; #1;
    chk("R10 preset after clear drops", mc_out, 1'b1);
    chk("R12 feedback under preset", mc_fb, 1'b1);
    in_vec = '0;
    tick();
  endtask

  initial begin
    std_terms();
    t_reset();
    t_literals();
    t_xor();
    t_dflop();
    t_tflop();
    t_jk();
    t_sr();
    t_latch();
    t_arrclk();
    t_prclr();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule